// File: doc/BRIEF.md
# Linear SVM Decision Evaluator

This block classifies one feature vector with a linear support vector machine whose trained parameters already sit in on-chip memories. After a start strobe it walks through the stored support vectors at a rate of one per clock. For each one it multiplies the six input components by the six stored components in parallel and sums them in a registered adder tree. At the same time it multiplies the mixing coefficient by the class label. The two results are then multiplied and added into a 48-bit accumulator.

Once the last contribution has been added and the pipeline is empty, the block raises a one-cycle done strobe. The class bit comes from the sign of the accumulator. All stored values and input features are 16-bit two's complement Q15 numbers. Every product is brought back to Q15 scale by an arithmetic right shift of 15, which rounds toward minus infinity.

The memory side is a plain read port: one shared address with an enable. The block assumes synchronous memories that return data on the cycle after the address. It has no back-pressure in either direction. A start strobe is taken only while the block is idle, and the result is offered for a single cycle with no hold-off. The caller must therefore sample `done_o` and `class_o` in that cycle.

Top module: `lsvm_eval`

## Requirements
- R1: Out of reset `done_o`, `class_o` and `rd_en_o` are low.
- R2: A start taken at clock edge E0 with count N ≥ 1 asserts `rd_en_o` for exactly the N cycles following E0, with `rd_addr_o` counting 0, 1, …, N-1 one step per cycle. The coefficient, label and all six support-vector words at an address are expected on `coef_i`, `label_i` and `sv_i` one cycle after that address is presented.
- R3: Each component product, the coefficient-times-label product and the final product are each shifted right arithmetically by 15 bits, which rounds toward minus infinity. The dot product is the sum of the six shifted component products. The accumulator adds, per support vector, (dot × weight) >>> 15 in 48-bit two's complement.
- R4: `class_o` is 1 when the final accumulator is ≥ 0, including exactly zero, and 0 when it is negative.
- R5: For N ≥ 1, `done_o` is high for exactly one cycle, N+7 cycles after the accepting edge E0. It is never high while a read is being issued.
- R6: A count of zero issues no reads and gives `done_o` one cycle after E0 with `class_o` = 1.
- R7: A start strobe raised while a classification is in progress is ignored. Its count and features have no effect on the read sequence, the timing or the class.
- R8: The accumulator is cleared on every accepted start, so a result never depends on an earlier run.
- R9: Counts up to 512 are supported, and exactly N reads are made for count N.
- R10: Features are captured on the accepting edge. Later changes on `feat_i` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| sv_count_i | input | 10 | Number of support vectors, 0 to 512 |
| feat_i | input | 6×16 | Feature vector, Q15 components, component k in bits [16k+15:16k] |
| rd_en_o | output | 1 | Read enable for the parameter memories |
| rd_addr_o | output | 9 | Support-vector index shared by all three memories |
| coef_i | input | 16 | Mixing coefficient read data, Q15 |
| label_i | input | 16 | Class label read data, Q15 |
| sv_i | input | 6×16 | Support-vector components read data, Q15 |
| done_o | output | 1 | One-cycle completion strobe |
| class_o | output | 1 | Class result, valid while done_o is high and held until the next one |

## Verification
The hardest situation to reach from the ports is an accumulator that ends at exactly zero, or that depends on the rounding direction of a negative product. Random data almost never lands on either. The stimulus builds them on purpose: a pair of support vectors whose weights cancel exactly, and a run of products equal to minus one least significant bit, where rounding toward zero would flip the class. A stray start in the middle of a run and a change of features during a run are driven while reads are in flight. A large positive run followed by a small negative one shows whether any state is carried over between runs.

// File: rtl/lsvm_pkg.sv
package lsvm_pkg;

  // Number of entries left at level lvl of a pairwise adder tree fed with n leaves.
  function automatic int tree_size(input int n, input int lvl);
    return (n + (1 << lvl) - 1) >> lvl;
  endfunction

endpackage

// File: rtl/lsvm_seq.sv
module lsvm_seq #(
  parameter int ADDR_W = 9,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  sv_count_i,
  input  logic              pipe_idle,
  output logic              accept,
  output logic              fin,
  output logic              busy,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              rd_v
);
  logic              issuing;
  logic [ADDR_W-1:0] idx;
  logic [CNT_W-1:0]  cnt;
  logic              last;

  assign accept    = start_i && !busy;
  assign fin       = busy && !issuing && pipe_idle;
  assign rd_en_o   = issuing;
  assign rd_addr_o = idx;
  assign last      = (CNT_W'(idx) + CNT_W'(1)) == cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      issuing <= 1'b0;
      idx     <= '0;
      cnt     <= '0;
      rd_v    <= 1'b0;
    end else begin
      rd_v <= issuing;
      if (accept) begin
        busy    <= 1'b1;
        issuing <= (sv_count_i != '0);
        idx     <= '0;
        cnt     <= sv_count_i;
      end else begin
        if (issuing) begin
          if (last) issuing <= 1'b0;
          else      idx     <= idx + 1'b1;
        end
        if (fin) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lsvm_dot.sv
module lsvm_dot import lsvm_pkg::*; #(
  parameter int NDIM   = 6,
  parameter int WORD_W = 16,
  parameter int FRAC   = 15,
  parameter int TREE_W = 40
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_v,
  input  logic [NDIM-1:0][WORD_W-1:0]  feat,
  input  logic [NDIM-1:0][WORD_W-1:0]  vec,
  output logic                         out_v,
  output logic                         any_v,
  output logic signed [TREE_W-1:0]     dot
);
  localparam int NLVL = $clog2(NDIM);

  logic signed [2*WORD_W-1:0] prod [NDIM];
  logic signed [TREE_W-1:0]   lvl  [NLVL+1][NDIM];
  logic [NLVL:0]              vld;

  for (genvar g = 0; g < NDIM; g++) begin : g_mul
    assign prod[g] = $signed(feat[g]) * $signed(vec[g]);
  end

  always_ff @(posedge clk) begin
    for (int g = 0; g < NDIM; g++) lvl[0][g] <= TREE_W'(prod[g] >>> FRAC);
    for (int l = 1; l <= NLVL; l++) begin
      for (int j = 0; j < NDIM; j++) begin
        if (j < tree_size(NDIM, l)) begin
          if (2*j+1 < tree_size(NDIM, l-1))
            lvl[l][j] <= lvl[l-1][2*j] + lvl[l-1][2*j+1];
          else
            lvl[l][j] <= lvl[l-1][2*j];
        end else begin
          lvl[l][j] <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vld <= '0;
    else        vld <= {vld[NLVL-1:0], in_v};
  end

  assign dot   = lvl[NLVL][0];
  assign out_v = vld[NLVL];
  assign any_v = |vld;
endmodule

// File: rtl/lsvm_weight.sv
module lsvm_weight #(
  parameter int WORD_W = 16,
  parameter int FRAC   = 15,
  parameter int DELAY  = 3,
  localparam int S_W   = 2*WORD_W - FRAC
) (
  input  logic                  clk,
  input  logic [WORD_W-1:0]     coef,
  input  logic [WORD_W-1:0]     label,
  output logic signed [S_W-1:0] w
);
  logic signed [2*WORD_W-1:0] raw;
  logic signed [S_W-1:0]      sd [DELAY+1];

  assign raw = $signed(coef) * $signed(label);

  always_ff @(posedge clk) begin
    sd[0] <= S_W'(raw >>> FRAC);
    for (int k = 1; k <= DELAY; k++) sd[k] <= sd[k-1];
  end

  assign w = sd[DELAY];
endmodule

// File: rtl/lsvm_eval.sv
module lsvm_eval #(
  parameter int NDIM    = 6,
  parameter int WORD_W  = 16,
  parameter int FRAC    = 15,
  parameter int TREE_W  = 40,
  parameter int ACC_W   = 48,
  parameter int MAX_SV  = 512,
  localparam int ADDR_W = $clog2(MAX_SV),
  localparam int CNT_W  = $clog2(MAX_SV + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic [CNT_W-1:0]            sv_count_i,
  input  logic [NDIM-1:0][WORD_W-1:0] feat_i,
  output logic                        rd_en_o,
  output logic [ADDR_W-1:0]           rd_addr_o,
  input  logic [WORD_W-1:0]           coef_i,
  input  logic [WORD_W-1:0]           label_i,
  input  logic [NDIM-1:0][WORD_W-1:0] sv_i,
  output logic                        done_o,
  output logic                        class_o
);
  localparam int NLVL = $clog2(NDIM);
  localparam int S_W  = 2*WORD_W - FRAC;

  logic accept, fin, busy, rd_v, dot_v, dot_busy, d_v, pipe_idle;
  logic [NDIM-1:0][WORD_W-1:0]   feat_q;
  logic signed [TREE_W-1:0]      dot;
  logic signed [S_W-1:0]         wgt;
  logic signed [TREE_W+S_W-1:0]  dprod;
  logic signed [ACC_W-1:0]       d_q, acc_q;

  assign pipe_idle = !(rd_v || dot_busy || d_v);

  lsvm_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sv_count_i(sv_count_i),
    .pipe_idle(pipe_idle), .accept(accept), .fin(fin), .busy(busy),
    .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_v(rd_v)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      feat_q <= '0;
    else if (accept) feat_q <= feat_i;
  end

  lsvm_dot #(.NDIM(NDIM), .WORD_W(WORD_W), .FRAC(FRAC), .TREE_W(TREE_W)) u_dot (
    .clk(clk), .rst_n(rst_n), .in_v(rd_v), .feat(feat_q), .vec(sv_i),
    .out_v(dot_v), .any_v(dot_busy), .dot(dot)
  );

  lsvm_weight #(.WORD_W(WORD_W), .FRAC(FRAC), .DELAY(NLVL)) u_wgt (
    .clk(clk), .coef(coef_i), .label(label_i), .w(wgt)
  );

  assign dprod = dot * wgt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_v     <= 1'b0;
      d_q     <= '0;
      acc_q   <= '0;
      done_o  <= 1'b0;
      class_o <= 1'b0;
    end else begin
      d_v <= dot_v;
      d_q <= ACC_W'(dprod >>> FRAC);
      if (accept)   acc_q <= '0;
      else if (d_v) acc_q <= acc_q + d_q;
      done_o <= fin;
      if (fin) class_o <= ~acc_q[ACC_W-1];
    end
  end
endmodule

// File: rtl/lsvm_eval_chk.sv
module lsvm_eval_chk #(
  parameter int ADDR_W = 9,
  parameter int CNT_W  = 10,
  parameter int ACC_W  = 48
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start_i,
  input logic [CNT_W-1:0]        sv_count_i,
  input logic                    busy,
  input logic                    rd_en_o,
  input logic [ADDR_W-1:0]       rd_addr_o,
  input logic                    done_o,
  input logic                    class_o,
  input logic signed [ACC_W-1:0] acc_q
);
  a_r1_quiet_reset: assert property (@(posedge clk)
    $fell(rst_n) |=> !done_o && !rd_en_o);

  a_r2_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy) |=> (rd_addr_o == '0) && (rd_en_o == ($past(sv_count_i) != '0)));

  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_o && $past(rd_en_o)) |-> rd_addr_o == $past(rd_addr_o) + 1'b1);

  a_r4_class_sign: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> class_o == ~acc_q[ACC_W-1]);

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r5_no_read_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !rd_en_o);

  a_r6_empty_run: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy && sv_count_i == '0) |=> ##1 (done_o && class_o));

  a_r8_acc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy) |=> acc_q == '0);
endmodule

bind lsvm_eval lsvm_eval_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .sv_count_i(sv_count_i),
  .busy(busy), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
  .done_o(done_o), .class_o(class_o), .acc_q(acc_q)
);

// File: tb/lsvm_eval_bench.sv
module lsvm_eval_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [9:0] sv_count_i = '0;
  logic [5:0][15:0] feat_drv = '0;
  logic rd_en_o;
  logic [8:0] rd_addr_o;
  logic [15:0] coef_r = '0, label_r = '0;
  logic [5:0][15:0] sv_r = '0;
  logic done_o, class_o;

  logic [15:0] coef_m [512];
  logic [15:0] label_m [512];
  logic [5:0][15:0] sv_m [512];

  int checks = 0, bad = 0, cyc = 0;
  int c0 = 0, exp_cyc = -1, exp_n = 0, exp_addr = 0, nreads = 0;
  bit active = 0, exp_class = 0, finished = 0;
  string cur_req = "R1";
  int unsigned lcg = 32'h1234_5678;

  always #2 clk = ~clk;

  lsvm_eval u_lsvm_eval (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sv_count_i(sv_count_i),
    .feat_i(feat_drv), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
    .coef_i(coef_r), .label_i(label_r), .sv_i(sv_r),
    .done_o(done_o), .class_o(class_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_en_o) begin
      coef_r  <= coef_m[rd_addr_o];
      label_r <= label_m[rd_addr_o];
      sv_r    <= sv_m[rd_addr_o];
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Cycle-by-cycle comparison against the behavioural model.
  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_rd, exp_done;
      exp_rd = active && cyc >= c0 && cyc < c0 + exp_n;
      check(rd_en_o == exp_rd, "R2", "read enable", rd_en_o, exp_rd);
      if (rd_en_o) begin
        check(rd_addr_o == exp_addr[8:0], "R2", "read address", rd_addr_o, exp_addr);
        exp_addr++;
        nreads++;
      end
      exp_done = active && cyc == exp_cyc;
      check(done_o == exp_done, (exp_n == 0) ? "R6" : "R5", "done strobe", done_o, exp_done);
      if (exp_done) begin
        check(class_o == exp_class, cur_req, "class", class_o, exp_class);
        check(nreads == exp_n, "R9", "read count", nreads, exp_n);
      end
    end
  end

  function automatic logic [15:0] rnd16();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg[31:16];
  endfunction

  task automatic fill_const(int n, logic [15:0] f, logic [15:0] x, logic [15:0] a, logic [15:0] y);
    for (int i = 0; i < n; i++) begin
      coef_m[i] = a; label_m[i] = y;
      for (int k = 0; k < 6; k++) sv_m[i][k] = x;
    end
    for (int k = 0; k < 6; k++) feat_drv[k] = f;
  endtask

  task automatic fill_rand(int n);
    for (int i = 0; i < n; i++) begin
      coef_m[i] = rnd16(); label_m[i] = rnd16();
      for (int k = 0; k < 6; k++) sv_m[i][k] = rnd16();
    end
    for (int k = 0; k < 6; k++) feat_drv[k] = rnd16();
  endtask

  // poke: 0 none, 1 stray start mid-run, 2 feature change mid-run
  task automatic run(int n, string req, int poke);
    longint acc = 0;
    for (int i = 0; i < n; i++) begin
      longint p = 0, s, d;
      for (int k = 0; k < 6; k++)
        p += (longint'($signed(feat_drv[k])) * longint'($signed(sv_m[i][k]))) >>> 15;
      s = (longint'($signed(coef_m[i])) * longint'($signed(label_m[i]))) >>> 15;
      d = (p * s) >>> 15;
      acc += d;
    end
    @(negedge clk);
    cur_req = req; exp_class = (acc >= 0); exp_n = n;
    c0 = cyc + 1; exp_cyc = c0 + ((n == 0) ? 1 : n + 7);
    exp_addr = 0; nreads = 0; active = 1;
    sv_count_i = n[9:0]; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke == 1) begin
      @(negedge clk); start_i = 1'b1; sv_count_i = 10'd3; feat_drv = ~feat_drv;
      @(negedge clk); start_i = 1'b0;
    end else if (poke == 2) begin
      @(negedge clk); feat_drv = ~feat_drv;
    end
    while (cyc <= exp_cyc) @(negedge clk);
    @(negedge clk);
    active = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(done_o == 1'b0, "R1", "done in reset", done_o, 0);
    check(class_o == 1'b0, "R1", "class in reset", class_o, 0);
    check(rd_en_o == 1'b0, "R1", "read enable in reset", rd_en_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    fill_const(1, 16'h4000, 16'h4000, 16'h7FFF, 16'h7FFF);
    run(1, "R4", 0);                          // positive -> class 1
    fill_const(1, 16'h4000, 16'h4000, 16'h7FFF, 16'h8000);
    run(1, "R4", 0);                          // negative -> class 0
    run(0, "R6", 0);                          // empty run -> class 1
    fill_const(2, 16'h4000, 16'h4000, 16'h4000, 16'h4000);
    label_m[1] = 16'hC000;
    run(2, "R4", 0);                          // exact zero -> class 1
    fill_const(6, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h7FFF);
    run(6, "R3", 0);                          // floor rounding -> class 0
    fill_const(512, 16'h8000, 16'h8000, 16'h8000, 16'h8000);
    run(512, "R9", 0);                        // full count, extreme values
    fill_const(1, 16'h4000, 16'h4000, 16'h7FFF, 16'h8000);
    run(1, "R8", 0);                          // follows large positive run
    for (int t = 0; t < 6; t++) begin
      fill_rand(37 + t * 29);
      run(37 + t * 29, "R3", 0);
    end
    fill_rand(300);
    run(300, "R7", 1);
    fill_rand(120);
    run(120, "R10", 2);
    fill_rand(512);
    run(512, "R9", 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; bad++;
      $display("FAIL %s watchdog: actual=%0d expected=%0d", cur_req, cyc, 0);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule